// File: doc/BRIEF.md
# Attraction-Memory Line Coherence Controller

This block keeps coherence state for the lines of one attraction memory in a cache-only machine built from a hierarchy of buses. There is no home memory. A line lives wherever it was last pulled in. The local processor issues reads and writes against a line index. The bus above delivers read, data, erase and exclusive-acknowledge transactions. The controller answers with read, data and erase transactions, which it places in a small output queue. The queue drains toward the bus under a ready signal.

Each line holds one of six states: three stable and three transient. A writer asks for ownership by sending an erase, then waits for the exclusive acknowledge. If a competing erase reaches it first, the writer has lost the race. It drops to a combined read-and-wait state, fetches the line again and sends a fresh erase. A processor request is held (not acknowledged) until its line can serve it. A line change that needs an outgoing transaction takes effect in the cycle the transaction enters the queue.

Top module: `amc_attraction_ctrl`

## Requirements
- R1: After reset every line is Invalid and the output queue is empty (`bus_valid` low).
- R2: Transaction kind codes on `net_kind` and `bus_kind` are 0 = read, 1 = data, 2 = erase and 3 = exclusive acknowledge. The controller never emits code 3. A processor read on an Invalid line queues a read and is not acknowledged. A later data arrival loads the line into Shared. The retried read is then acknowledged with the delivered value on `proc_rdata`.
- R3: A processor write on a Shared line queues an erase and is not acknowledged. An exclusive acknowledge then moves the line to Exclusive. The retried write is acknowledged there.
- R4: An erase arriving for a Shared line makes it Invalid, so a following processor read queues a read again.
- R5: A line waiting for ownership that receives an erase queues a read. The data that answers that read causes an erase to be queued again.
- R6: A processor write on an Invalid line queues a read. The data that answers it causes an erase to be queued, and the exclusive acknowledge lets the write complete.
- R7: On an Exclusive line, reads and writes are acknowledged with no bus traffic. A read arriving from the bus queues a data reply carrying the line's value and leaves the line Shared.
- R8: A processor request to a line in a transient state is not acknowledged and queues nothing.
- R9: When the output queue is full, a processor request that would queue a transaction is stalled and the line state is unchanged. The queue never accepts an entry while full.
- R10: A bus transaction in a cycle takes precedence: a processor request presented in the same cycle is not served.
- R11: An erase arriving for an Invalid line and a read arriving for a Shared line queue nothing and change nothing that is visible.
- R12: The head of the output queue holds its kind, index and data until `bus_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_valid | input | 1 | Processor request present |
| proc_write | input | 1 | 1 = write, 0 = read |
| proc_idx | input | IDX_W | Line addressed by the processor |
| proc_wdata | input | DATA_W | Write value |
| proc_ack | output | 1 | Request served this cycle |
| proc_rdata | output | DATA_W | Value of the addressed line |
| net_valid | input | 1 | Bus transaction arriving this cycle |
| net_kind | input | 2 | Arriving transaction kind |
| net_idx | input | IDX_W | Line of the arriving transaction |
| net_data | input | DATA_W | Data carried by a data transaction |
| bus_valid | output | 1 | Output queue head valid |
| bus_kind | output | 2 | Head transaction kind |
| bus_idx | output | IDX_W | Head line index |
| bus_data | output | DATA_W | Head data (zero unless kind is data) |
| bus_ready | input | 1 | Bus takes the head this cycle |

## Verification
The overflow property assumes that the bus above never sends a transaction that needs a reply (a read to an Exclusive line, or data to a line in the read-and-wait state) while the output queue is full. Bus-side events are always consumed, and only processor requests can be held back. The stimulus keeps to this by raising `bus_ready` after each step. The queue is filled only with processor requests, which stall correctly. The ordering properties also assume the bus sends exclusive acknowledges and data only to lines that are waiting for them. The stimulus sequences each line through legal request and reply pairs.

// File: rtl/amc_pkg.sv
package amc_pkg;

   typedef enum logic [2:0] {
      LS_INV  = 3'd0,
      LS_RD   = 3'd1,
      LS_RDW  = 3'd2,
      LS_WT   = 3'd3,
      LS_SHR  = 3'd4,
      LS_EXC  = 3'd5
   } line_st_e;

   typedef enum logic [1:0] {
      TX_READ  = 2'd0,
      TX_DATA  = 2'd1,
      TX_ERASE = 2'd2,
      TX_EXCL  = 2'd3
   } txn_e;

   function automatic logic is_settled(line_st_e s);
      return (s == LS_INV) || (s == LS_SHR) || (s == LS_EXC);
   endfunction

endpackage

// File: rtl/amc_line_fsm.sv
module amc_line_fsm
   import amc_pkg::*;
(
   input  logic     evt_valid,
   input  logic     evt_is_net,
   input  txn_e     net_kind,
   input  logic     proc_write,
   input  line_st_e cur_st,
   input  logic     room,
   output line_st_e nxt_st,
   output logic     emit,
   output txn_e     emit_kind,
   output logic     load_net,
   output logic     load_proc,
   output logic     served
);

   always_comb begin
      nxt_st    = cur_st;
      emit      = 1'b0;
      emit_kind = TX_READ;
      load_net  = 1'b0;
      load_proc = 1'b0;
      served    = 1'b0;
      if (evt_valid && evt_is_net) begin
         unique case (net_kind)
            TX_READ: begin
               if (cur_st == LS_EXC) begin
                  emit      = 1'b1;
                  emit_kind = TX_DATA;
                  nxt_st    = LS_SHR;
               end
            end
            TX_DATA: begin
               if (cur_st == LS_RD) begin
                  load_net = 1'b1;
                  nxt_st   = LS_SHR;
               end else if (cur_st == LS_RDW) begin
                  load_net  = 1'b1;
                  emit      = 1'b1;
                  emit_kind = TX_ERASE;
                  nxt_st    = LS_WT;
               end
            end
            TX_ERASE: begin
               if (cur_st == LS_SHR) begin
                  nxt_st = LS_INV;
               end else if (cur_st == LS_WT) begin
                  emit      = 1'b1;
                  emit_kind = TX_READ;
                  nxt_st    = LS_RDW;
               end
            end
            TX_EXCL: begin
               if (cur_st == LS_WT) nxt_st = LS_EXC;
            end
            default: ;
         endcase
      end else if (evt_valid) begin
         unique case (cur_st)
            LS_INV: begin
               if (room) begin
                  emit      = 1'b1;
                  emit_kind = TX_READ;
                  nxt_st    = proc_write ? LS_RDW : LS_RD;
               end
            end
            LS_SHR: begin
               if (!proc_write) begin
                  served = 1'b1;
               end else if (room) begin
                  emit      = 1'b1;
                  emit_kind = TX_ERASE;
                  nxt_st    = LS_WT;
               end
            end
            LS_EXC: begin
               served    = 1'b1;
               load_proc = proc_write;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/amc_line_store.sv
module amc_line_store
   import amc_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_LINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_st_e          wr_st,
   input  logic              wr_load,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output line_st_e          rd_a_st,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data
);

   line_st_e          st_q   [NUM_LINES];
   logic [DATA_W-1:0] data_q [NUM_LINES];

   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(gi));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[gi]   <= LS_INV;
            data_q[gi] <= '0;
         end else if (sel) begin
            st_q[gi] <= wr_st;
            if (wr_load) data_q[gi] <= wr_data;
         end
      end
   end

   assign rd_a_st   = st_q[rd_a_idx];
   assign rd_a_data = data_q[rd_a_idx];
   assign rd_b_data = data_q[rd_b_idx];

endmodule

// File: rtl/amc_obuf.sv
module amc_obuf #(
   parameter int W     = 13,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_msg,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         not_empty,
   output logic         full
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign not_empty = (cnt != '0);
   assign full      = (cnt == CNT_W'(DEPTH));
   assign do_push   = push && !full;
   assign do_pop    = pop && not_empty;
   assign head      = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_msg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/amc_attraction_ctrl.sv
module amc_attraction_ctrl
   import amc_pkg::*;
#(
   parameter int NUM_LINES  = 8,
   parameter int DATA_W     = 8,
   parameter int OBUF_DEPTH = 4,
   localparam int IDX_W     = $clog2(NUM_LINES),
   localparam int MSG_W     = 2 + IDX_W + DATA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_valid,
   input  logic              proc_write,
   input  logic [IDX_W-1:0]  proc_idx,
   input  logic [DATA_W-1:0] proc_wdata,
   output logic              proc_ack,
   output logic [DATA_W-1:0] proc_rdata,
   input  logic              net_valid,
   input  logic [1:0]        net_kind,
   input  logic [IDX_W-1:0]  net_idx,
   input  logic [DATA_W-1:0] net_data,
   output logic              bus_valid,
   output logic [1:0]        bus_kind,
   output logic [IDX_W-1:0]  bus_idx,
   output logic [DATA_W-1:0] bus_data,
   input  logic              bus_ready
);

   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (OBUF_DEPTH < 2) begin : g_bad_depth
      $error("OBUF_DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic              evt_valid;
   logic [IDX_W-1:0]  evt_idx;
   line_st_e          cur_st, nxt_st;
   logic [DATA_W-1:0] cur_data;
   logic              emit, load_net, load_proc, served;
   txn_e              emit_kind;
   logic              obuf_full, push_req;
   logic [MSG_W-1:0]  push_msg, head_msg;
   logic [DATA_W-1:0] push_data;

   assign evt_valid = net_valid || proc_valid;
   assign evt_idx   = net_valid ? net_idx : proc_idx;

   amc_line_fsm u_fsm (
      .evt_valid  (evt_valid),
      .evt_is_net (net_valid),
      .net_kind   (txn_e'(net_kind)),
      .proc_write (proc_write),
      .cur_st     (cur_st),
      .room       (!obuf_full),
      .nxt_st     (nxt_st),
      .emit       (emit),
      .emit_kind  (emit_kind),
      .load_net   (load_net),
      .load_proc  (load_proc),
      .served     (served)
   );

   amc_line_store #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (evt_valid),
      .wr_idx    (evt_idx),
      .wr_st     (nxt_st),
      .wr_load   (load_net || load_proc),
      .wr_data   (load_net ? net_data : proc_wdata),
      .rd_a_idx  (evt_idx),
      .rd_a_st   (cur_st),
      .rd_a_data (cur_data),
      .rd_b_idx  (proc_idx),
      .rd_b_data (proc_rdata)
   );

   assign push_req  = emit;
   assign push_data = (emit_kind == TX_DATA) ? cur_data : '0;
   assign push_msg  = {emit_kind, evt_idx, push_data};

   amc_obuf #(.W(MSG_W), .DEPTH(OBUF_DEPTH)) u_obuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_req),
      .push_msg  (push_msg),
      .pop       (bus_ready),
      .head      (head_msg),
      .not_empty (bus_valid),
      .full      (obuf_full)
   );

   assign bus_kind = head_msg[MSG_W-1 -: 2];
   assign bus_idx  = head_msg[DATA_W +: IDX_W];
   assign bus_data = head_msg[DATA_W-1:0];
   assign proc_ack = served;

endmodule

// File: rtl/amc_attraction_ctrl_chk.sv
module amc_attraction_ctrl_chk #(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              proc_valid,
   input logic              proc_ack,
   input logic              net_valid,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic [1:0]        bus_kind,
   input logic [IDX_W-1:0]  bus_idx,
   input logic [DATA_W-1:0] bus_data,
   input logic              push,
   input logic              full
);

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   p_net_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      proc_ack |-> (proc_valid && !net_valid));

   p_head_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=>
         (bus_valid && $stable(bus_kind) && $stable(bus_idx) && $stable(bus_data)));

   p_no_excl_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_kind != 2'd3));

endmodule

bind amc_attraction_ctrl amc_attraction_ctrl_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .proc_valid (proc_valid),
   .proc_ack   (proc_ack),
   .net_valid  (net_valid),
   .bus_valid  (bus_valid),
   .bus_ready  (bus_ready),
   .bus_kind   (bus_kind),
   .bus_idx    (bus_idx),
   .bus_data   (bus_data),
   .push       (push_req),
   .full       (obuf_full)
);

// File: tb/amc_attraction_ctrl_test.sv
module amc_attraction_ctrl_test;

   localparam int CLK_P = 10;
   localparam int NV    = 26;

   // src: 0 proc read, 1 proc write, 2 net read, 3 net data, 4 net erase, 5 net excl
   typedef struct packed {
      logic [2:0] src;
      logic [2:0] idx;
      logic [7:0] d;
      logic       ack;
      logic [7:0] rd;
      logic       bv;
      logic [1:0] bk;
      logic [7:0] bd;
      logic [3:0] req;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{3'd0, 3'd1, 8'h00, 1'b0, 8'h00, 1'b1, 2'd0, 8'h00, 4'd2},  // R2 miss
      '{3'd3, 3'd1, 8'h5A, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 fill
      '{3'd0, 3'd1, 8'h00, 1'b1, 8'h5A, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 hit
      '{3'd1, 3'd1, 8'h77, 1'b0, 8'h00, 1'b1, 2'd2, 8'h00, 4'd3},  // R3 erase
      '{3'd0, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd8},  // R8 stall
      '{3'd5, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd3},  // R3 excl
      '{3'd1, 3'd1, 8'h77, 1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 4'd3},  // R3 write
      '{3'd0, 3'd1, 8'h00, 1'b1, 8'h77, 1'b0, 2'd0, 8'h00, 4'd7},  // R7 local
      '{3'd2, 3'd1, 8'h00, 1'b0, 8'h00, 1'b1, 2'd1, 8'h77, 4'd7},  // R7 reply
      '{3'd0, 3'd1, 8'h00, 1'b1, 8'h77, 1'b0, 2'd0, 8'h00, 4'd7},  // R7 shared
      '{3'd4, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd4},  // R4 erase
      '{3'd0, 3'd1, 8'h00, 1'b0, 8'h00, 1'b1, 2'd0, 8'h00, 4'd4},  // R4 re-read
      '{3'd3, 3'd1, 8'h33, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 fill
      '{3'd1, 3'd2, 8'h11, 1'b0, 8'h00, 1'b1, 2'd0, 8'h00, 4'd6},  // R6 write miss
      '{3'd3, 3'd2, 8'h20, 1'b0, 8'h00, 1'b1, 2'd2, 8'h00, 4'd5},  // R5 data->erase
      '{3'd4, 3'd2, 8'h00, 1'b0, 8'h00, 1'b1, 2'd0, 8'h00, 4'd5},  // R5 lost race
      '{3'd3, 3'd2, 8'h21, 1'b0, 8'h00, 1'b1, 2'd2, 8'h00, 4'd5},  // R5 retry
      '{3'd5, 3'd2, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd6},  // R6 excl
      '{3'd1, 3'd2, 8'h11, 1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 4'd6},  // R6 done
      '{3'd0, 3'd2, 8'h00, 1'b1, 8'h11, 1'b0, 2'd0, 8'h00, 4'd7},  // R7 value
      '{3'd4, 3'd3, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd11}, // R11 erase in I
      '{3'd2, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd11}, // R11 read in S
      '{3'd0, 3'd3, 8'h00, 1'b0, 8'h00, 1'b1, 2'd0, 8'h00, 4'd11}, // R11 still I
      '{3'd0, 3'd3, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd8},  // R8 in reading
      '{3'd3, 3'd3, 8'h44, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 fill
      '{3'd0, 3'd3, 8'h00, 1'b1, 8'h44, 1'b0, 2'd0, 8'h00, 4'd2}   // R2 hit
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       proc_valid = 1'b0, proc_write = 1'b0;
   logic [2:0] proc_idx = '0;
   logic [7:0] proc_wdata = '0;
   logic       proc_ack;
   logic [7:0] proc_rdata;
   logic       net_valid = 1'b0;
   logic [1:0] net_kind = '0;
   logic [2:0] net_idx = '0;
   logic [7:0] net_data = '0;
   logic       bus_valid;
   logic [1:0] bus_kind;
   logic [2:0] bus_idx;
   logic [7:0] bus_data;
   logic       bus_ready = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   amc_attraction_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .proc_valid(proc_valid), .proc_write(proc_write), .proc_idx(proc_idx),
      .proc_wdata(proc_wdata), .proc_ack(proc_ack), .proc_rdata(proc_rdata),
      .net_valid(net_valid), .net_kind(net_kind), .net_idx(net_idx), .net_data(net_data),
      .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_idx(bus_idx), .bus_data(bus_data),
      .bus_ready(bus_ready)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] src, input logic [2:0] idx, input logic [7:0] d);
      proc_valid = (src <= 3'd1);
      proc_write = (src == 3'd1);
      proc_idx   = idx;
      proc_wdata = d;
      net_valid  = (src >= 3'd2);
      net_kind   = (src >= 3'd2) ? 2'(src - 3'd2) : 2'd0;
      net_idx    = idx;
      net_data   = d;
   endtask

   task automatic idle();
      proc_valid = 1'b0;
      net_valid  = 1'b0;
   endtask

   task automatic pop_one();
      if (bus_valid) begin
         bus_ready = 1'b1;
         @(negedge clk);
         bus_ready = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: queue empty, line 0 Invalid
      check("R1 bus_valid after reset", 16'(bus_valid), 16'd0);
      drive(3'd0, 3'd0, 8'h00);
      #1;
      check("R1 read of fresh line ack", 16'(proc_ack), 16'd0);
      @(negedge clk);
      idle();
      #1;
      check("R1 fresh line queues read", {bus_valid, 5'd0, bus_kind, 5'd0, bus_idx}, {1'b1, 5'd0, 2'd0, 5'd0, 3'd0});
      pop_one();

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         drive(VECS[v].src, VECS[v].idx, VECS[v].d);
         #1;
         check($sformatf("R%0d vec%0d ack", VECS[v].req, v), 16'(proc_ack), 16'(VECS[v].ack));
         if (VECS[v].ack && VECS[v].src == 3'd0)
            check($sformatf("R%0d vec%0d rdata", VECS[v].req, v), 16'(proc_rdata), 16'(VECS[v].rd));
         @(negedge clk);
         idle();
         #1;
         check($sformatf("R%0d vec%0d bus_valid", VECS[v].req, v), 16'(bus_valid), 16'(VECS[v].bv));
         if (VECS[v].bv)
            check($sformatf("R%0d vec%0d bus msg", VECS[v].req, v),
                  {bus_kind, bus_idx, 3'd0, bus_data}, {VECS[v].bk, VECS[v].idx, 3'd0, VECS[v].bd});
         pop_one();
      end

      // R10: bus event in the same cycle wins over a hit on line 1 (Shared, 0x33)
      @(negedge clk);
      drive(3'd4, 3'd5, 8'h00);
      proc_valid = 1'b1;
      proc_write = 1'b0;
      proc_idx   = 3'd1;
      #1;
      check("R10 proc not served under net event", 16'(proc_ack), 16'd0);
      @(negedge clk);
      idle();
      drive(3'd0, 3'd1, 8'h00);
      #1;
      check("R10 served when alone", {7'd0, proc_ack, proc_rdata}, {7'd0, 1'b1, 8'h33});
      @(negedge clk);
      idle();

      // R9 and R12: fill queue without draining
      for (int k = 4; k < 8; k++) begin
         @(negedge clk);
         drive(3'd0, 3'(k), 8'h00);
         #1;
         check("R9 fill ack", 16'(proc_ack), 16'd0);
      end
      @(negedge clk);
      drive(3'd1, 3'd1, 8'h99);
      #1;
      check("R9 write stalled when full", 16'(proc_ack), 16'd0);
      @(negedge clk);
      idle();
      #1;
      check("R12 head unchanged while blocked", {bus_valid, 5'd0, bus_kind, 5'd0, bus_idx}, {1'b1, 5'd0, 2'd0, 5'd0, 3'd4});
      begin
         int n_out;
         n_out = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (bus_valid) begin
               check("R12 drain order", 16'(bus_idx), 16'(3'd4 + 3'(n_out)));
               n_out++;
               bus_ready = 1'b1;
            end else begin
               bus_ready = 1'b0;
            end
         end
         bus_ready = 1'b0;
         check("R9 nothing queued beyond depth", 16'(n_out), 16'd4);
      end
      @(negedge clk);
      drive(3'd0, 3'd1, 8'h00);
      #1;
      check("R9 stalled write left line Shared", {7'd0, proc_ack, proc_rdata}, {7'd0, 1'b1, 8'h33});
      @(negedge clk);
      idle();
      @(negedge clk);
      #1;
      check("R9 no erase was queued", 16'(bus_valid), 16'd0);

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule